// File: doc/BRIEF.md
# Binary-Coded Calendar Timekeeper

This block keeps wall-clock time and a calendar date in binary-coded decimal. Its clock is a 32.768 kHz reference. A free-running prescaler of `DIV_W` bits divides that reference down to a one-second tick. On each tick the block advances seconds, minutes, hours, day of week, date, month and a two-digit year. It handles month lengths and the February leap day correctly for every year from 2000 through 2099.

A host loads any field through a byte-wide write strobe. Every write restarts the second, so the first tick after a write comes one full second later. Reads go through a snapshot. A read strobe copies all seven fields at once, and the host then selects bytes from that copy with a read address. A tick that lands in the middle of a multi-byte read therefore cannot give the host a torn time value.

Top module: `bcd_calendar_top`

## Requirements
- R1: After reset the time is 00:00:00, the day of week is 0, and the date is 01, month 01, year 00. After reset, a read strobe returns these values and the tick output is low.
- R2: With no host writes, `sec_tick` is high for one clock in every 2^DIV_W clocks. The time changes only on those clocks.
- R3: A write with `wr_en` high loads `wr_data` into the field selected by `wr_addr` (0 sec, 1 min, 2 hour, 3 day of week, 4 date, 5 month, 6 year). All other fields stay unchanged.
- R4: Any write strobe clears the prescaler, so the next tick is high on the 2^DIV_W-th clock after the write edge. A write in a tick cycle wins, and that tick advances nothing.
- R5: Seconds and minutes count 00 to 59 in BCD, and hours count 00 to 23. Each field wraps to 00 and carries into the next field.
- R6: Day of week counts 0 to 6 and wraps to 0. It advances at the same midnight as the date.
- R7: Months 04, 06, 09 and 11 roll to day 01 of the next month after day 30. Months 01, 03, 05, 07, 08, 10 and 12 roll after day 31.
- R8: February rolls after day 29 when the two-digit year is divisible by four (00 counts as a leap year). Otherwise it rolls after day 28.
- R9: Month 12 rolls to month 01 and advances the year. Year 99 wraps to 00.
- R10: `rd_data` shows the field selected by `rd_addr` as it stood at the last `rd_stb` clock. Later ticks do not change it until the next strobe. Address 7 reads 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Field selected for the write |
| wr_data | input | 8 | BCD value to load |
| rd_stb | input | 1 | Captures all fields into the read snapshot |
| rd_addr | input | 3 | Field selected from the snapshot |
| rd_data | output | 8 | Selected snapshot field |
| sec_tick | output | 1 | One-clock pulse marking each second |

## Verification
The carry chain is tested with start times just below each boundary: a minute carry, a midnight in a 31-day month at mid-month, the last day of a 30-day month, and New Year's Eve of year 99. Each one shows whether the carry stops at the right field. The February cases use years 24, 23, 12, 10 and 00. They separate a true divisible-by-four test from checks that look only at the units digit or only at the parity of the tens digit. The tick spacing is measured twice: after a single write, and after a second write placed part-way through a second. The second case separates a prescaler that is cleared from one that is left running. The snapshot case reads the fields long after a midnight rollover has happened. This shows the read path is decoupled from the live counters.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int NFLD = 7;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] dow;
    logic [7:0] date;
    logic [7:0] month;
    logic [7:0] year;
  } cal_time_t;

  // lowest legal value of each field, also its reset value
  function automatic logic [7:0] fld_base(input int idx);
    case (idx)
      4, 5:    fld_base = 8'h01;
      default: fld_base = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // (10*t + o) mod 4 equals (2*t + o) mod 4
  function automatic logic leap_year(input logic [7:0] yr);
    logic [4:0] s;
    s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
    leap_year = (s[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      month_end = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_end = 8'h30;
      default:                    month_end = 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int DIV_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = &cnt_q;
endmodule

// File: rtl/cal_bcd_wrap_counter.sv
module cal_bcd_wrap_counter #(
  parameter logic [7:0] LO = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] hi,
  input  logic       step,
  input  logic       load,
  input  logic [7:0] load_val,
  output logic [7:0] value,
  output logic       at_top
);
  logic [7:0] val_d;

  assign at_top = (value >= hi);

  always_comb begin
    val_d = value;
    if (load)      val_d = load_val;
    else if (step) val_d = at_top ? LO : cal_pkg::bcd_inc(value);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= LO;
    else        value <= val_d;
  end
endmodule

// File: rtl/cal_timekeeper.sv
module cal_timekeeper
  import cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output cal_time_t now
);
  logic [7:0] fval [NFLD];
  logic [7:0] fhi  [NFLD];
  logic       ftop [NFLD];
  logic       fstep[NFLD];
  logic       fload[NFLD];
  logic adv, sec_roll, min_roll, day_roll, date_roll, mon_roll;

  always_comb begin
    fhi[0] = 8'h59;
    fhi[1] = 8'h59;
    fhi[2] = 8'h23;
    fhi[3] = 8'h06;
    fhi[4] = month_end(fval[5], leap_year(fval[6]));
    fhi[5] = 8'h12;
    fhi[6] = 8'h99;
  end

  always_comb begin
    adv       = tick & ~wr_en;
    sec_roll  = adv & ftop[0];
    min_roll  = sec_roll & ftop[1];
    day_roll  = min_roll & ftop[2];
    date_roll = day_roll & ftop[4];
    mon_roll  = date_roll & ftop[5];
    fstep[0] = adv;
    fstep[1] = sec_roll;
    fstep[2] = min_roll;
    fstep[3] = day_roll;
    fstep[4] = day_roll;
    fstep[5] = date_roll;
    fstep[6] = mon_roll;
  end

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    assign fload[i] = wr_en && (wr_addr == 3'(i));
    cal_bcd_wrap_counter #(.LO(fld_base(i))) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .hi       (fhi[i]),
      .step     (fstep[i]),
      .load     (fload[i]),
      .load_val (wr_data),
      .value    (fval[i]),
      .at_top   (ftop[i])
    );
  end

  assign now = '{sec: fval[0], min: fval[1], hour: fval[2], dow: fval[3],
                 date: fval[4], month: fval[5], year: fval[6]};
endmodule

// File: rtl/cal_snapshot.sv
module cal_snapshot
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap,
  input  cal_time_t  live,
  input  logic [2:0] rd_addr,
  output cal_time_t  held,
  output logic [7:0] rd_data
);
  cal_time_t held_d;
  localparam cal_time_t SNAP_RST = '{sec: fld_base(0), min: fld_base(1), hour: fld_base(2),
                                     dow: fld_base(3), date: fld_base(4), month: fld_base(5),
                                     year: fld_base(6)};

  always_comb held_d = cap ? live : held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= SNAP_RST;
    else        held <= held_d;
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = held.sec;
      3'd1:    rd_data = held.min;
      3'd2:    rd_data = held.hour;
      3'd3:    rd_data = held.dow;
      3'd4:    rd_data = held.date;
      3'd5:    rd_data = held.month;
      3'd6:    rd_data = held.year;
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/bcd_calendar_top.sv
module bcd_calendar_top #(
  parameter int DIV_W       = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_stb,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       sec_tick
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_s_n;
  cal_pkg::cal_time_t     live_time, held_time;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe[SYNC_STAGES-1];

  cal_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_s_n),
    .clr   (wr_en),
    .tick  (sec_tick)
  );

  cal_timekeeper u_time (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .tick    (sec_tick),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .now     (live_time)
  );

  cal_snapshot u_snap (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .cap     (rd_stb),
    .live    (live_time),
    .rd_addr (rd_addr),
    .held    (held_time),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/cal_checker.sv
module cal_checker
  import cal_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       rd_stb,
  input cal_time_t  live,
  input cal_time_t  held
);
  AST_IDLE_HOLDS_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(live)); // R2

  AST_WRITE_LOADS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> (live.sec == $past(wr_data))); // R3

  AST_WRITE_KEEPS_MONTH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != 3'd5) |=> (live.month == $past(live.month))); // R3

  AST_WRITE_RESTARTS_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tick); // R4

  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (live.sec <= 8'h59 && live.min <= 8'h59)); // R5

  AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    live.hour <= 8'h23); // R5

  AST_MIN_HOLD_MIDSEC: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && live.sec != 8'h59) |=> $stable(live.min)); // R5

  AST_DOW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    live.dow <= 8'h06); // R6

  AST_MIDNIGHT_DOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && live.sec == 8'h59 && live.min == 8'h59 && live.hour == 8'h23)
    |=> (live.dow == (($past(live.dow) == 8'h06) ? 8'h00 : $past(live.dow) + 8'h01))); // R6

  AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(held)); // R10

  AST_SNAP_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (held == $past(live))); // R10
endmodule

bind bcd_calendar_top cal_checker u_cal_chk (
  .clk     (clk),
  .rst_n   (rst_s_n),
  .tick    (sec_tick),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .rd_stb  (rd_stb),
  .live    (live_time),
  .held    (held_time)
);

// File: tb/tb_bcd_calendar_top.sv
`timescale 1ns/1ps
module tb_bcd_calendar_top;
  localparam int DIV_W = 4;
  localparam int PER   = 1 << DIV_W;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_stb = 1'b0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       sec_tick;

  int n_tests = 0;
  int n_fail  = 0;
  logic mon_vld = 1'b0;
  logic [7:0] q_data[$];
  logic [2:0] q_addr[$];
  string      q_tag[$];

  always #4 clk = ~clk;

  bcd_calendar_top #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .sec_tick(sec_tick)
  );

  // monitor: pops expected bytes and compares them with the read port
  always @(negedge clk) begin
    if (mon_vld && q_data.size() > 0) begin
      logic [7:0] e;
      logic [2:0] a;
      string t;
      e = q_data.pop_front();
      a = q_addr.pop_front();
      t = q_tag.pop_front();
      n_tests++;
      if (rd_data !== e) begin
        n_fail++;
        $display("FAIL %s field %0d: got %h expected %h", t, a, rd_data, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, dw, dt, mo, yr);
    wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, dw);
    wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, yr);
  endtask

  task automatic strobe();
    @(posedge clk); #1; rd_stb = 1'b1;
    @(posedge clk); #1; rd_stb = 1'b0;
  endtask

  task automatic read_fields(input logic [7:0] s, m, h, dw, dt, mo, yr, input string tag);
    logic [7:0] v[7];
    v[0] = s; v[1] = m; v[2] = h; v[3] = dw; v[4] = dt; v[5] = mo; v[6] = yr;
    for (int i = 0; i < 7; i++) begin
      @(posedge clk); #1;
      rd_addr = 3'(i);
      q_data.push_back(v[i]); q_addr.push_back(3'(i)); q_tag.push_back(tag);
      mon_vld = 1'b1;
    end
    @(posedge clk); #1;
    mon_vld = 1'b0;
  endtask

  task automatic expect_time(input logic [7:0] s, m, h, dw, dt, mo, yr, input string tag);
    strobe();
    read_fields(s, m, h, dw, dt, mo, yr, tag);
  endtask

  task automatic advance(input int secs);
    repeat (secs * PER) @(posedge clk);
  endtask

  task automatic check_int(input int got, input int exp, input string tag);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic gap_to_tick(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!sec_tick);
  endtask

  // midnight rollover from the given date, expecting the next date
  task automatic day_roll(input logic [7:0] dw, dt, mo, yr, ndt, nmo, nyr, input string tag);
    logic [7:0] ndw;
    ndw = (dw == 8'h06) ? 8'h00 : dw + 8'h01;
    set_time(8'h59, 8'h59, 8'h23, dw, dt, mo, yr);
    advance(1);
    expect_time(8'h00, 8'h00, 8'h00, ndw, ndt, nmo, nyr, tag);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int k;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_int(int'(sec_tick), 0, "R1 tick low after reset");
    expect_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, "R1 reset time");

    // R3: full load and single-field write
    set_time(8'h56, 8'h34, 8'h12, 8'h03, 8'h15, 8'h07, 8'h24);
    expect_time(8'h56, 8'h34, 8'h12, 8'h03, 8'h15, 8'h07, 8'h24, "R3 load all");
    wr(3'd1, 8'h45);
    expect_time(8'h56, 8'h45, 8'h12, 8'h03, 8'h15, 8'h07, 8'h24, "R3 single field");

    // R4 first gap after a write, R2 steady gap
    wr(3'd0, 8'h10);
    gap_to_tick(k); check_int(k, PER, "R4 first tick after write");
    gap_to_tick(k); check_int(k, PER, "R2 tick period");
    wr(3'd0, 8'h10);
    repeat (10) @(posedge clk);
    wr(3'd0, 8'h20);
    gap_to_tick(k); check_int(k, PER, "R4 second write restarts second");

    // R4: write landing on a tick cycle wins
    set_time(8'h20, 8'h15, 8'h08, 8'h02, 8'h10, 8'h03, 8'h30);
    do @(negedge clk); while (!sec_tick);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h30;
    @(posedge clk); #1; wr_en = 1'b0;
    expect_time(8'h30, 8'h15, 8'h08, 8'h02, 8'h10, 8'h03, 8'h30, "R4 write beats tick");

    // R5: second, minute, hour carries
    set_time(8'h58, 8'h59, 8'h10, 8'h01, 8'h05, 8'h05, 8'h21);
    advance(1);
    expect_time(8'h59, 8'h59, 8'h10, 8'h01, 8'h05, 8'h05, 8'h21, "R5 plain second");
    set_time(8'h58, 8'h59, 8'h10, 8'h01, 8'h05, 8'h05, 8'h21);
    advance(2);
    expect_time(8'h00, 8'h00, 8'h11, 8'h01, 8'h05, 8'h05, 8'h21, "R5 hour carry");
    set_time(8'h09, 8'h29, 8'h19, 8'h01, 8'h05, 8'h05, 8'h21);
    advance(1);
    expect_time(8'h10, 8'h29, 8'h19, 8'h01, 8'h05, 8'h05, 8'h21, "R5 bcd digit carry");

    // R6, R7: mid-month midnight and month ends
    day_roll(8'h06, 8'h15, 8'h05, 8'h21, 8'h16, 8'h05, 8'h21, "R6 dow wrap mid-month");
    day_roll(8'h02, 8'h30, 8'h04, 8'h21, 8'h01, 8'h05, 8'h21, "R7 april 30");
    day_roll(8'h02, 8'h30, 8'h11, 8'h21, 8'h01, 8'h12, 8'h21, "R7 november 30");
    day_roll(8'h02, 8'h30, 8'h05, 8'h21, 8'h31, 8'h05, 8'h21, "R7 may 30");
    day_roll(8'h04, 8'h31, 8'h01, 8'h21, 8'h01, 8'h02, 8'h21, "R7 january 31");

    // R8: leap years
    day_roll(8'h00, 8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24, "R8 2024 feb 28");
    day_roll(8'h01, 8'h29, 8'h02, 8'h24, 8'h01, 8'h03, 8'h24, "R8 2024 feb 29");
    day_roll(8'h00, 8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23, "R8 2023 feb 28");
    day_roll(8'h00, 8'h28, 8'h02, 8'h12, 8'h29, 8'h02, 8'h12, "R8 2012 feb 28");
    day_roll(8'h00, 8'h28, 8'h02, 8'h10, 8'h01, 8'h03, 8'h10, "R8 2010 feb 28");
    day_roll(8'h00, 8'h28, 8'h02, 8'h00, 8'h29, 8'h02, 8'h00, "R8 2000 feb 28");

    // R9: year end
    day_roll(8'h03, 8'h31, 8'h12, 8'h41, 8'h01, 8'h01, 8'h42, "R9 new year");
    day_roll(8'h06, 8'h31, 8'h12, 8'h99, 8'h01, 8'h01, 8'h00, "R9 year 99 wrap");

    // R10: snapshot stays put across a rollover
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h05);
    strobe();
    advance(3);
    read_fields(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h05, "R10 held snapshot");
    @(posedge clk); #1; rd_addr = 3'd7;
    @(negedge clk);
    check_int(int'(rd_data), 0, "R10 unmapped address");

    finish_run();
  end
endmodule